// File: doc/BRIEF.md
# Power-Down Mode Controller

This block chooses the low-power state of a small microcontroller and drives the gating and reset controls that go with it. The CPU issues a one-cycle sleep strobe. The value of a software-standby select bit on that clock edge picks the state. When the bit is 0 the block enters light sleep: only the CPU clock stops. When the bit is 1 it enters software standby: the CPU clock and peripheral clocks stop, the peripherals are reset, and the I/O outputs keep their last values. An active-low standby pin overrides everything else. It forces hardware standby, which also turns off the I/O drivers. When the pin is released, the block leaves hardware standby through a reset sequence of fixed length, so the CPU restarts instead of resuming.

A wake request returns the block to active. From sleep this happens on the next cycle. From software standby the block first holds the clocks off for a programmable settle count, which stands in for the time the oscillator needs to recover. All outputs are decoded from the state register, so they change one clock edge after the input that causes the change.

The states are ACTIVE, LSLEEP, SSTBY, SETTLE, HSTBY and HEXIT. The transitions are:
- ACTIVE to LSLEEP on a strobe with the select bit at 0.
- ACTIVE to SSTBY on a strobe with the select bit at 1.
- LSLEEP to ACTIVE on a wake request.
- SSTBY to SETTLE on a wake request, or straight to ACTIVE when the settle count is 0.
- SETTLE to ACTIVE when the count runs out.
- Any state to HSTBY when the pin is low.
- HSTBY to HEXIT when the pin goes high.
- HEXIT to ACTIVE after `RST_CYCLES` cycles.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the block is in ACTIVE. `mode_o` is 2'b00, both clock enables are 1, and `periph_rst_o`, `ram_keep_o`, `io_hold_o`, `io_off_o` and `cpu_rst_o` are 0.
- R2: A `sleep_stb` in ACTIVE with `ssby_sel` at 0 and `stby_n` high gives LSLEEP on the next cycle. `mode_o` is 2'b01, `cpu_clk_en_o` is 0, `periph_clk_en_o` is 1, `ram_keep_o` is 1, and all other controls are 0.
- R3: A `sleep_stb` in ACTIVE with `ssby_sel` at 1 gives SSTBY on the next cycle. `mode_o` is 2'b10, both clock enables are 0, `periph_rst_o`, `ram_keep_o` and `io_hold_o` are 1, and `io_off_o` and `cpu_rst_o` are 0.
- R4: `ssby_sel` is looked at only on the edge that accepts the strobe. Changes to `ssby_sel`, and further strobes, while in a low-power state leave `mode_o` and all controls unchanged.
- R5: `stby_n` low, seen on an edge in any state, gives HSTBY on the next cycle. `mode_o` is 2'b11, both clock enables are 0, `periph_rst_o`, `ram_keep_o`, `io_off_o` and `cpu_rst_o` are 1, and `io_hold_o` is 0.
- R6: While `stby_n` is low, `sleep_stb` and `wake_req` have no effect.
- R7: When `stby_n` goes high in HSTBY, the block spends exactly `RST_CYCLES` cycles in HEXIT and then enters ACTIVE. In HEXIT, `mode_o` is 2'b11, both clock enables are 1, `periph_rst_o`, `cpu_rst_o`, `io_off_o` and `ram_keep_o` are 1, and `io_hold_o` is 0.
- R8: A `wake_req` in LSLEEP gives ACTIVE on the next cycle.
- R9: A `wake_req` in SSTBY with `settle_cnt` = N keeps the SSTBY outputs (mode 2'b10) for N cycles after the wake edge and then gives ACTIVE. With N = 0, ACTIVE follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_stb | input | 1 | One-cycle sleep request from the CPU |
| ssby_sel | input | 1 | Selects software standby (1) or sleep (0) |
| stby_n | input | 1 | Active-low hardware standby pin, already synchronous |
| wake_req | input | 1 | Enabled interrupt request |
| settle_cnt | input | CW | Settle cycles after a wake from software standby |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| periph_rst_o | output | 1 | Peripheral reset |
| ram_keep_o | output | 1 | RAM retain flag |
| io_hold_o | output | 1 | Hold I/O outputs at their last values |
| io_off_o | output | 1 | Turn off the I/O output drivers |
| cpu_rst_o | output | 1 | CPU reset |
| mode_o | output | 2 | Mode: 00 active, 01 sleep, 10 software standby, 11 hardware standby |

## Verification
The hardest states to reach are SETTLE and HEXIT, because each lasts only a few cycles after a wake request or a pin release. The bench reaches them by sweeping the settle count from 0 to 5 and counting the cycles. It also drops `stby_n` while the block is in each state, including one cycle into SETTLE and one cycle into HEXIT, so that the override is shown to win from every state. After each drop it holds the pin low while pulsing strobes and wake requests, to show they have no effect.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_LSLEEP = 3'd1,
        ST_SSTBY  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_HSTBY  = 3'd4,
        ST_HEXIT  = 3'd5
    } pd_state_e;

    typedef struct packed {
        logic       cpu_clk_en;
        logic       periph_clk_en;
        logic       periph_rst;
        logic       ram_keep;
        logic       io_hold;
        logic       io_off;
        logic       cpu_rst;
        logic [1:0] mode;
    } pd_ctrl_t;

endpackage

// File: rtl/pwrdn_timer.sv
module pwrdn_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == CW'(1));

    // R9 / R7: the count stays at zero once it gets there
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/pwrdn_decode.sv
module pwrdn_decode
    import pwrdn_pkg::*;
(
    input  pd_state_e state_i,
    output pd_ctrl_t  ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        unique case (state_i)
            ST_ACTIVE: begin
                ctrl_o.cpu_clk_en    = 1'b1;
                ctrl_o.periph_clk_en = 1'b1;
                ctrl_o.mode          = 2'b00;
            end
            ST_LSLEEP: begin
                ctrl_o.periph_clk_en = 1'b1;
                ctrl_o.ram_keep      = 1'b1;
                ctrl_o.mode          = 2'b01;
            end
            ST_SSTBY, ST_SETTLE: begin
                ctrl_o.periph_rst = 1'b1;
                ctrl_o.ram_keep   = 1'b1;
                ctrl_o.io_hold    = 1'b1;
                ctrl_o.mode       = 2'b10;
            end
            ST_HSTBY: begin
                ctrl_o.periph_rst = 1'b1;
                ctrl_o.ram_keep   = 1'b1;
                ctrl_o.io_off     = 1'b1;
                ctrl_o.cpu_rst    = 1'b1;
                ctrl_o.mode       = 2'b11;
            end
            ST_HEXIT: begin
                ctrl_o.cpu_clk_en    = 1'b1;
                ctrl_o.periph_clk_en = 1'b1;
                ctrl_o.periph_rst    = 1'b1;
                ctrl_o.ram_keep      = 1'b1;
                ctrl_o.io_off        = 1'b1;
                ctrl_o.cpu_rst       = 1'b1;
                ctrl_o.mode          = 2'b11;
            end
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int CW         = 8,
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_stb,
    input  logic          ssby_sel,
    input  logic          stby_n,
    input  logic          wake_req,
    input  logic [CW-1:0] settle_cnt,
    output logic          cpu_clk_en_o,
    output logic          periph_clk_en_o,
    output logic          periph_rst_o,
    output logic          ram_keep_o,
    output logic          io_hold_o,
    output logic          io_off_o,
    output logic          cpu_rst_o,
    output logic [1:0]    mode_o
);
    localparam logic [CW-1:0] RST_LEN = CW'(RST_CYCLES);

    pd_state_e     state_q, state_d;
    logic          tmr_load, tmr_last;
    logic [CW-1:0] tmr_len;
    pd_ctrl_t      ctrl;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = settle_cnt;
        if (!stby_n) begin
            state_d = ST_HSTBY;
        end else begin
            unique case (state_q)
                ST_ACTIVE: if (sleep_stb) state_d = ssby_sel ? ST_SSTBY : ST_LSLEEP;
                ST_LSLEEP: if (wake_req)  state_d = ST_ACTIVE;
                ST_SSTBY: if (wake_req) begin
                    tmr_load = 1'b1;
                    state_d  = (settle_cnt == '0) ? ST_ACTIVE : ST_SETTLE;
                end
                ST_SETTLE: if (tmr_last) state_d = ST_ACTIVE;
                ST_HSTBY: begin
                    tmr_load = 1'b1;
                    tmr_len  = RST_LEN;
                    state_d  = ST_HEXIT;
                end
                ST_HEXIT: if (tmr_last) state_d = ST_ACTIVE;
                default: state_d = ST_ACTIVE;
            endcase
        end
    end

    pwrdn_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    pwrdn_decode u_decode (
        .state_i (state_q),
        .ctrl_o  (ctrl)
    );

    assign cpu_clk_en_o    = ctrl.cpu_clk_en;
    assign periph_clk_en_o = ctrl.periph_clk_en;
    assign periph_rst_o    = ctrl.periph_rst;
    assign ram_keep_o      = ctrl.ram_keep;
    assign io_hold_o       = ctrl.io_hold;
    assign io_off_o        = ctrl.io_off;
    assign cpu_rst_o       = ctrl.cpu_rst;
    assign mode_o          = ctrl.mode;

    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && sleep_stb && !ssby_sel && stby_n) |=> (mode_o == 2'b01));

    assert_soft_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && sleep_stb && ssby_sel && stby_n) |=> (mode_o == 2'b10 && !cpu_clk_en_o));

    assert_sleep_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && stby_n && !wake_req) |=> (mode_o == 2'b01));

    assert_hw_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby_n) |=> (mode_o == 2'b11 && io_off_o && !cpu_clk_en_o));

    assert_hw_exit_only_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |=> (mode_o == 2'b11 || (mode_o == 2'b00 && $past(cpu_rst_o))));

    assert_sleep_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && wake_req && stby_n) |=> (mode_o == 2'b00));
endmodule

// File: tb/pwrdn_ctrl_test.sv
module pwrdn_ctrl_test;
    localparam int CW = 8;
    localparam int RC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_stb = 1'b0, ssby_sel = 1'b0, stby_n = 1'b1, wake_req = 1'b0;
    logic [CW-1:0] settle_cnt = '0;
    logic cpu_clk_en_o, periph_clk_en_o, periph_rst_o, ram_keep_o;
    logic io_hold_o, io_off_o, cpu_rst_o;
    logic [1:0] mode_o;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwrdn_ctrl #(.CW(CW), .RST_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .ssby_sel(ssby_sel),
        .stby_n(stby_n), .wake_req(wake_req), .settle_cnt(settle_cnt),
        .cpu_clk_en_o(cpu_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
        .periph_rst_o(periph_rst_o), .ram_keep_o(ram_keep_o),
        .io_hold_o(io_hold_o), .io_off_o(io_off_o), .cpu_rst_o(cpu_rst_o),
        .mode_o(mode_o));

    // expected {mode, cpu_clk, per_clk, per_rst, keep, hold, off, cpu_rst}
    // m: 0 active, 1 sleep, 2 soft standby, 3 hard standby, 4 reset exit
    function automatic logic [8:0] expv(int m);
        case (m)
            0: return {2'b00, 7'b1100000};
            1: return {2'b01, 7'b0101000};
            2: return {2'b10, 7'b0011100};
            3: return {2'b11, 7'b0011011};
            default: return {2'b11, 7'b1111011};
        endcase
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(int m, string req);
        logic [8:0] act;
        act = {mode_o, cpu_clk_en_o, periph_clk_en_o, periph_rst_o, ram_keep_o,
               io_hold_o, io_off_o, cpu_rst_o};
        checks++;
        if (act !== expv(m)) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, expv(m));
        end
    endtask

    task automatic go_sleep(bit sel);
        ssby_sel = sel; sleep_stb = 1'b1; tick(); sleep_stb = 1'b0;
    endtask

    task automatic wake_soft(int n);
        settle_cnt = CW'(n); wake_req = 1'b1; tick(); wake_req = 1'b0;
        for (int i = 0; i < n; i++) begin chk(2, "R9 settle"); tick(); end
        chk(0, "R9 active after settle");
    endtask

    task automatic hw_cycle(string tag);
        stby_n = 1'b0; tick(); chk(3, {"R5 ", tag});
        for (int i = 0; i < 3; i++) begin
            sleep_stb = 1'b1; wake_req = 1'b1; ssby_sel = i[0];
            tick(); chk(3, "R6 ignore strobe/wake");
        end
        sleep_stb = 1'b0; wake_req = 1'b0;
        stby_n = 1'b1; tick();
        for (int i = 0; i < RC; i++) begin chk(4, "R7 reset exit"); tick(); end
        chk(0, "R7 active after exit");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        chk(0, "R1 reset state");
        tick(); chk(0, "R1 idle active");

        for (int s = 0; s < 2; s++) begin
            go_sleep(s[0]); chk(s == 0 ? 1 : 2, s == 0 ? "R2 sleep entry" : "R3 soft entry");
            for (int i = 0; i < 3; i++) begin
                ssby_sel = ~ssby_sel; sleep_stb = 1'b1; tick();
                chk(s == 0 ? 1 : 2, "R4 select/strobe ignored");
            end
            sleep_stb = 1'b0;
            if (s == 0) begin
                wake_req = 1'b1; tick(); wake_req = 1'b0; chk(0, "R8 wake from sleep");
            end else begin
                wake_soft(2);
            end
        end

        for (int n = 0; n <= 5; n++) begin
            go_sleep(1'b1); chk(2, "R3 soft entry");
            wake_soft(n);
        end

        hw_cycle("from active");
        go_sleep(1'b0); hw_cycle("from sleep");
        go_sleep(1'b1); hw_cycle("from soft standby");
        go_sleep(1'b1); settle_cnt = CW'(3); wake_req = 1'b1; tick(); wake_req = 1'b0;
        chk(2, "R9 settle entered"); hw_cycle("from settle");
        stby_n = 1'b0; tick(); stby_n = 1'b1; tick(); chk(4, "R7 exit begins");
        hw_cycle("from reset exit");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule